// File: doc/BRIEF.md
# Dual-Rail Codec with Completion Detection

This block carries a single-rail data word across a self-timed link. The transmit half turns a W-bit word into a 2W-wire bus where every bit owns a pair of rails, so each bit says by itself whether it holds data. The receive half watches such a bus and uses a tree of state-holding C-elements to report completion. Completion rises once every bit carries a legal value, and falls once every bit has gone back to the empty state. Illegal pairs set a sticky error flag.

Each C-element is modelled as a clocked hysteresis gate, so the block is fully synchronous and synthesizable. The transmitter follows return-to-zero four-phase discipline. It launches a word, keeps it on the bus until the receive half reports completion, then drives the empty pattern. It accepts nothing new until completion has fallen again. The transmitter takes its completion from this block's own receive half, so the bus is meant to be looped back, either directly or through a link that keeps the pairs intact.

Top module: `dr_codec`

## Requirements
- R1: Bit i of a word uses rails tx_bus[2i+1] (the one-rail) and tx_bus[2i] (the zero-rail). A 1 drives 2'b10 on {tx_bus[2i+1], tx_bus[2i]}, a 0 drives 2'b01, and the empty (spacer) state is 2'b00. The receive half decodes bit i of a legal pair as rx_bus[2i+1].
- R2: A word is accepted at a clock edge where tx_valid and tx_ready are both high. From that edge on, tx_bus shows the codeword and holds it unchanged until the first edge at which rx_done is high. From that edge, tx_bus is all spacer.
- R3: tx_ready is low while a codeword is being driven and while rx_done is high. Any tx_valid seen while tx_ready is low has no effect on tx_bus or on the word delivered.
- R4: Starting from a spacer bus with rx_done low, rx_done rises exactly $clog2(W) clock edges after every pair on rx_bus becomes legal and valid, rounding W up to a power of two. It stays low while any pair is spacer or illegal.
- R5: Once high, rx_done stays high while only some pairs have returned to spacer. It falls exactly $clog2(W) edges after every pair is spacer.
- R6: rx_word loads the decoded rx_bus at the edge after rx_done rises and holds its value at all other edges, including the whole spacer phase.
- R7: A pair with both rails high is illegal and does not count as valid. It sets rx_err at the next edge, and rx_err then stays high until reset.
- R8: While rst_n is low at a clock edge (synchronous, active low), all C-element states clear to 0. After that edge tx_bus is spacer, rx_done, rx_err and rx_word are 0, and tx_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_valid | input | 1 | Request to send tx_data |
| tx_data | input | W | Single-rail word to send |
| tx_ready | output | 1 | Transmitter can accept a word |
| tx_bus | output | 2W | Dual-rail transmit bus |
| rx_bus | input | 2W | Dual-rail receive bus |
| rx_word | output | W | Last completed word, decoded |
| rx_done | output | 1 | Completion-tree output |
| rx_err | output | 1 | Sticky illegal-pair flag |

## Verification
The word capture and the transmitter's return to spacer fall on the same edge: the edge after rx_done rises. When the bus is looped back, every transfer provokes this collision. The bench judges it by sampling, in the following cycle, an all-spacer tx_bus next to an rx_word equal to the word that was sent. Each of the sixteen words of a four-bit configuration goes through this collision, some of them while a competing tx_valid is held high. Directly forced bus patterns then exercise the hysteresis and the illegal pairs separately.

// File: rtl/dr_codec_pkg.sv
// Package: shared types and rail-pair helpers for the dual-rail codec.
// Assumes the rail order {one-rail, zero-rail} within each bit pair.
package dr_codec_pkg;

    typedef enum logic {
        TX_IDLE  = 1'b0,
        TX_DRIVE = 1'b1
    } tx_state_e;

    localparam logic [1:0] PAIR_SPACER = 2'b00;

    // Rail pair for one data bit: 1 -> 2'b10, 0 -> 2'b01.
    function automatic logic [1:0] pair_of(input logic b);
        return b ? 2'b10 : 2'b01;
    endfunction

endpackage

// File: rtl/dr_celement.sv
// Module: clocked C-element with N_IN inputs.
// The output goes to 1 when all inputs are 1 and to 0 when all inputs are 0.
// Otherwise it keeps its state. Assumes inputs are stable at each clock edge.
module dr_celement #(
    parameter int N_IN = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_IN-1:0] in_bits,
    output logic            y
);

    // State update with hysteresis.
    always_ff @(posedge clk) begin
        if (!rst_n)          y <= 1'b0;
        else if (&in_bits)   y <= 1'b1;
        else if (~|in_bits)  y <= 1'b0;
    end

    assert_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (&in_bits) |=> y);
    assert_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (~|in_bits) |=> !y);
    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (|in_bits && !(&in_bits)) |=> $stable(y));

endmodule

// File: rtl/dr_done_tree.sv
// Module: binary completion tree of clocked C-elements over per-bit validity.
// Leaves are padded to a power of two by repeating bit 0. Repeating a bit
// leaves every C-element function unchanged. Latency is $clog2(W) edges.
// Assumes W >= 2.
module dr_done_tree #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] valid,
    output logic         done
);

    localparam int DEPTH  = $clog2(W);
    localparam int LEAVES = 1 << DEPTH;

    // Heap-ordered nodes: 1 is the root, LEAVES..2*LEAVES-1 are the leaves.
    logic node [1:2*LEAVES-1];

    for (genvar i = 0; i < LEAVES; i++) begin : g_leaf
        if (i < W) begin : g_real
            assign node[LEAVES+i] = valid[i];
        end else begin : g_pad
            assign node[LEAVES+i] = valid[0];
        end
    end

    for (genvar k = 1; k < LEAVES; k++) begin : g_node
        dr_celement #(.N_IN(2)) u_cel (
            .clk     (clk),
            .rst_n   (rst_n),
            .in_bits ({node[2*k+1], node[2*k]}),
            .y       (node[k])
        );
    end

    assign done = node[1];

endmodule

// File: rtl/dr_tx.sv
// Module: dual-rail transmitter with four-phase return to spacer.
// It launches a word only when idle and completion is low, holds the codeword
// until completion is seen, then drives spacer. Assumes rx_done comes from a
// receiver that watches this bus.
module dr_tx
    import dr_codec_pkg::*;
#(
    parameter int W = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           tx_valid,
    input  logic [W-1:0]   tx_data,
    input  logic           rx_done,
    output logic           tx_ready,
    output logic [2*W-1:0] tx_bus
);

    tx_state_e      state;
    logic [2*W-1:0] code;

    // Codeword for the offered data word.
    for (genvar i = 0; i < W; i++) begin : g_enc
        assign code[2*i+1 -: 2] = pair_of(tx_data[i]);
    end

    // Ready only when idle and the previous word has fully drained.
    assign tx_ready = (state == TX_IDLE) && !rx_done;

    // Launch, hold, and return-to-spacer sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= TX_IDLE;
            tx_bus <= '0;
        end else begin
            case (state)
                TX_IDLE: begin
                    if (tx_valid && tx_ready) begin
                        tx_bus <= code;
                        state  <= TX_DRIVE;
                    end
                end
                TX_DRIVE: begin
                    if (rx_done) begin
                        tx_bus <= '0;
                        state  <= TX_IDLE;
                    end
                end
                default: state <= TX_IDLE;
            endcase
        end
    end

    assert_codeword_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (|tx_bus && |$past(tx_bus)) |-> $stable(tx_bus));
    assert_launch_after_rtz_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (|tx_bus && !(|$past(tx_bus))) |-> !$past(rx_done));

endmodule

// File: rtl/dr_rx_decode.sv
// Module: dual-rail receive decoder.
// It produces per-bit validity for the completion tree, flags illegal pairs
// stickily, and loads the decoded word on the rising edge of completion.
// Assumes the bus holds the codeword while completion is rising.
module dr_rx_decode #(
    parameter int W = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [2*W-1:0] rx_bus,
    input  logic           rx_done,
    output logic [W-1:0]   bit_valid,
    output logic [W-1:0]   rx_word,
    output logic           rx_err
);

    logic [W-1:0] illegal;
    logic [W-1:0] decoded;
    logic         done_d;

    // Per-bit classification of each rail pair.
    for (genvar i = 0; i < W; i++) begin : g_pair
        assign bit_valid[i] = rx_bus[2*i+1] ^ rx_bus[2*i];
        assign illegal[i]   = rx_bus[2*i+1] & rx_bus[2*i];
        assign decoded[i]   = rx_bus[2*i+1];
    end

    // Edge tracking of completion and capture of the word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_d  <= 1'b0;
            rx_word <= '0;
        end else begin
            done_d <= rx_done;
            if (rx_done && !done_d) rx_word <= decoded;
        end
    end

    // Sticky illegal-code flag.
    always_ff @(posedge clk) begin
        if (!rst_n)        rx_err <= 1'b0;
        else if (|illegal) rx_err <= 1'b1;
    end

    assert_word_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_done && !done_d) |=> $stable(rx_word));
    assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_err |=> rx_err);
    assert_err_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (|illegal) |=> rx_err);

endmodule

// File: rtl/dr_codec.sv
// Module: top of the dual-rail codec.
// It ties the transmitter, the receive decoder and the completion tree
// together. The transmitter paces itself on this block's own completion,
// so rx_bus is expected to carry tx_bus back. Assumes W >= 2.
module dr_codec #(
    parameter int W = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           tx_valid,
    input  logic [W-1:0]   tx_data,
    output logic           tx_ready,
    output logic [2*W-1:0] tx_bus,
    input  logic [2*W-1:0] rx_bus,
    output logic [W-1:0]   rx_word,
    output logic           rx_done,
    output logic           rx_err
);

    logic [W-1:0] bit_valid;

    dr_tx #(.W(W)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .tx_valid (tx_valid),
        .tx_data  (tx_data),
        .rx_done  (rx_done),
        .tx_ready (tx_ready),
        .tx_bus   (tx_bus)
    );

    dr_rx_decode #(.W(W)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_bus    (rx_bus),
        .rx_done   (rx_done),
        .bit_valid (bit_valid),
        .rx_word   (rx_word),
        .rx_err    (rx_err)
    );

    dr_done_tree #(.W(W)) u_tree (
        .clk   (clk),
        .rst_n (rst_n),
        .valid (bit_valid),
        .done  (rx_done)
    );

endmodule

// File: tb/dr_codec_tb_top.sv
// Bench: exhaustive loopback sweep of a 4-bit codec plus forced-bus cases.
module dr_codec_tb_top;

    localparam int W = 4;
    localparam int D = $clog2(W);

    logic           clk = 1'b0;
    logic           rst_n;
    logic           tx_valid;
    logic [W-1:0]   tx_data;
    logic           tx_ready;
    logic [2*W-1:0] tx_bus;
    logic [2*W-1:0] rx_bus;
    logic [W-1:0]   rx_word;
    logic           rx_done;
    logic           rx_err;
    logic           loop;
    logic [2*W-1:0] force_bus;

    int n_cmp = 0;
    int n_bad = 0;
    bit fin   = 1'b0;

    always #10 clk = ~clk;

    assign rx_bus = loop ? tx_bus : force_bus;

    dr_codec #(.W(W)) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .tx_valid (tx_valid),
        .tx_data  (tx_data),
        .tx_ready (tx_ready),
        .tx_bus   (tx_bus),
        .rx_bus   (rx_bus),
        .rx_word  (rx_word),
        .rx_done  (rx_done),
        .rx_err   (rx_err)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // R1 encoding: one-rail at 2i+1, zero-rail at 2i.
    function automatic logic [2*W-1:0] enc(input logic [W-1:0] w);
        logic [2*W-1:0] e;
        for (int i = 0; i < W; i++) begin
            e[2*i+1] = w[i];
            e[2*i]   = ~w[i];
        end
        return e;
    endfunction

    // Loopback transfer of one word; noise holds a competing tx_valid.
    task automatic send(input logic [W-1:0] w, input bit noise);
        @(negedge clk);
        chk("R3 ready before send", tx_ready, 1);
        tx_valid = 1'b1;
        tx_data  = w;
        @(negedge clk);
        chk("R1 R2 codeword driven", tx_bus, enc(w));
        chk("R4 done low at launch", rx_done, 0);
        chk("R3 ready low while driving", tx_ready, 0);
        if (noise) tx_data = ~w;
        else       tx_valid = 1'b0;
        for (int k = 1; k < D; k++) begin
            @(negedge clk);
            chk("R4 done still low", rx_done, 0);
            chk("R2 codeword held", tx_bus, enc(w));
        end
        @(negedge clk);
        chk("R4 done rises after depth", rx_done, 1);
        chk("R3 codeword held despite tx_valid", tx_bus, enc(w));
        @(negedge clk);
        chk("R6 word captured", rx_word, w);
        chk("R2 spacer after done", tx_bus, 0);
        chk("R3 ready low while done", tx_ready, 0);
        tx_valid = 1'b0;
        for (int k = 1; k < D; k++) begin
            @(negedge clk);
            chk("R5 done still high", rx_done, 1);
            chk("R6 word held", rx_word, w);
        end
        @(negedge clk);
        chk("R5 done falls after depth", rx_done, 0);
        chk("R3 ready after done fell", tx_ready, 1);
        chk("R6 word held in spacer", rx_word, w);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!fin) begin
            n_bad++;
            n_cmp++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [2*W-1:0] pat;
        rst_n     = 1'b0;
        tx_valid  = 1'b0;
        tx_data   = '0;
        loop      = 1'b1;
        force_bus = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R8 bus spacer", tx_bus, 0);
        chk("R8 done low", rx_done, 0);
        chk("R8 err low", rx_err, 0);
        chk("R8 word zero", rx_word, 0);
        chk("R8 ready high", tx_ready, 1);

        // Exhaustive loopback sweep; odd words carry a competing request.
        for (int w = 0; w < (1 << W); w++) send(w[W-1:0], w[0]);

        // Hysteresis on the way up and down, forced bus (R4, R5, R6).
        @(negedge clk);
        loop      = 1'b0;
        force_bus = enc(4'hA);
        for (int k = 1; k < D; k++) begin
            @(negedge clk);
            chk("R4 forced done low", rx_done, 0);
        end
        @(negedge clk);
        chk("R4 forced done high", rx_done, 1);
        @(negedge clk);
        chk("R6 forced word", rx_word, 4'hA);
        pat = enc(4'hA);
        pat[3:2] = 2'b00;
        force_bus = pat;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            chk("R5 done holds on partial spacer", rx_done, 1);
            chk("R6 word holds on partial spacer", rx_word, 4'hA);
        end
        force_bus = '0;
        for (int k = 1; k < D; k++) begin
            @(negedge clk);
            chk("R5 done holds before fall", rx_done, 1);
        end
        @(negedge clk);
        chk("R5 done falls forced", rx_done, 0);
        pat = enc(4'h5);
        pat[7:6] = 2'b00;
        force_bus = pat;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            chk("R4 done low on partial valid", rx_done, 0);
            chk("R6 word holds in partial valid", rx_word, 4'hA);
        end
        force_bus = '0;
        repeat (4) @(negedge clk);

        // Illegal pair (R7).
        chk("R7 err clear before", rx_err, 0);
        pat = enc(4'h3);
        pat[5:4] = 2'b11;
        force_bus = pat;
        @(negedge clk);
        chk("R7 err set", rx_err, 1);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            chk("R7 illegal pair not valid", rx_done, 0);
        end
        force_bus = '0;
        repeat (4) @(negedge clk);
        chk("R7 err sticky", rx_err, 1);
        loop = 1'b1;
        send(4'h6, 1'b0);
        chk("R7 err sticky after transfer", rx_err, 1);

        // Reset mid-run (R8).
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        chk("R8 err cleared", rx_err, 0);
        chk("R8 word cleared", rx_word, 0);
        chk("R8 done cleared", rx_done, 0);
        chk("R8 ready after reset", tx_ready, 1);
        send(4'h9, 1'b1);

        fin = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule